// File: doc/BRIEF.md
# Virtual-PC Indirect Target Predictor

This block predicts the target of an indirect branch without a dedicated indirect-target table. It reuses two smaller structures: a direction table of 2-bit counters and a direct-mapped target buffer. An indirect branch is treated as a chain of virtual conditional branches. The block tests them one per clock. Step 0 uses the branch's own PC and global history. Each later step XORs the PC with a per-step hash constant and shifts the history one place left, with a zero filled in at the bottom. The first step whose counter says taken supplies the target that the buffer holds under that step's virtual PC. The chain ends with no target on a buffer miss, or when every allowed step has been tested.

A training request carries the resolved target and walks the same chain. Steps that hold a wrong target are pushed toward not-taken. The step that holds the right target is pushed toward taken. If no step holds it, the target is written at the first empty step, or at the final step when every step is occupied, and that step is pushed toward taken. A request is accepted only while the block is idle. The result comes out as a one-cycle pulse.

Top module: `vpc_indirect_pred`

## Requirements
- R1: After reset, busy and pred_valid are low, and every buffer entry is empty, so the first prediction reports no hit at step 0.
- R2: A prediction stops at the lowest step whose counter MSB is 1 and whose buffer entry hits. It reports pred_hit=1, that entry's target, and the step number on pred_iter.
- R3: Step i reads under virtual PC = pc XOR (i*HASH_K mod 2^PC_W), where step 0 uses the real PC. The history for step i is hist shifted left by i with zeros filled in. The counter index is the low DIR_IW bits of the virtual PC XOR that history.
- R4: A buffer miss at any step ends the prediction with pred_hit=0 at that step.
- R5: If MAX_ITER steps all hit with not-taken counters, the prediction ends with pred_hit=0 and pred_iter=MAX_ITER-1.
- R6: Steps advance one per clock. pred_valid pulses for one cycle, j+1 edges after the accepting edge, where j is the final step. busy is high from the accepting edge until that pulse.
- R7: req_valid and train_valid are ignored while busy is high. If both are high in an idle cycle, the prediction is taken and the training is dropped.
- R8: In training, the step whose entry holds the resolved target has its counter incremented. Each earlier step has its counter decremented.
- R9: In training, the first step that misses in the buffer gets the resolved target written there, and its counter is incremented.
- R10: In training, if all MAX_ITER steps hit with wrong targets, the last step's entry is overwritten with the resolved target, and its counter is incremented instead of decremented.
- R11: Counters are 2-bit and saturate at 0 and 3. They reset to 1, and a step predicts taken when the counter MSB is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a prediction |
| req_pc | input | PC_W | PC of the indirect branch to predict |
| req_hist | input | DIR_IW | Global history for the prediction |
| train_valid | input | 1 | Start a training walk |
| train_pc | input | PC_W | PC of the resolved branch |
| train_hist | input | DIR_IW | History the branch was predicted with |
| train_target | input | PC_W | Resolved target |
| busy | output | 1 | A walk is in progress |
| pred_valid | output | 1 | One-cycle result pulse |
| pred_hit | output | 1 | A target was found |
| pred_target | output | PC_W | Predicted target, meaningful when pred_hit is high |
| pred_iter | output | ITER_W | Step at which the walk ended |

## Verification
On every cycle, the assertions check these properties:
- Walk steps advance by exactly one per cycle.
- A result pulse occurs only in idle.
- A hit never appears without a pulse.
- An accepted PC stays fixed while a new request arrives during a walk.
- A freshly written buffer entry reads back its target.

Only the bench's scenarios can show that the counters and buffer actually learn. These scenarios chain training walks with known outcomes and then check:
- which step each later prediction stops at;
- counter saturation;
- the all-not-taken give-up;
- the overwrite of the last step;
- that requests arriving while busy leave no trace.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRED  = 2'd1,
    ST_TRAIN = 2'd2
  } vpc_state_e;
endpackage

// File: rtl/vpc_dir_table.sv
module vpc_dir_table #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] idx,
  output logic          taken,
  input  logic          wr_en,
  input  logic          wr_taken
);
  localparam int N = 1 << IW;

  logic [1:0] ctr_q [N];
  logic [1:0] cur;
  logic [1:0] nxt;

  always_comb begin
    cur = ctr_q[idx];
    if (wr_taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else          nxt = (cur == 2'b00) ? cur : cur - 2'd1;
  end

  assign taken = cur[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) ctr_q[k] <= 2'b01;
    end else if (wr_en) begin
      ctr_q[idx] <= nxt;
    end
  end
endmodule

// File: rtl/vpc_btb.sv
module vpc_btb #(
  parameter int PC_W = 16,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc,
  output logic            hit,
  output logic [PC_W-1:0] target,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_target
);
  localparam int N     = 1 << IW;
  localparam int TAG_W = PC_W - IW;

  logic             vld_q [N];
  logic [TAG_W-1:0] tag_q [N];
  logic [PC_W-1:0]  tgt_q [N];
  logic [IW-1:0]    slot;
  logic [TAG_W-1:0] tag;

  assign slot   = pc[IW-1:0];
  assign tag    = pc[PC_W-1:IW];
  assign hit    = vld_q[slot] && (tag_q[slot] == tag);
  assign target = tgt_q[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) vld_q[k] <= 1'b0;
    end else if (wr_en) begin
      vld_q[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[slot] <= tag;
      tgt_q[slot] <= wr_target;
    end
  end

  AST_INSTALL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pc != $past(pc)) || (hit && target == $past(wr_target))); // R9
endmodule

// File: rtl/vpc_indirect_pred.sv
module vpc_indirect_pred
  import vpc_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter int              DIR_IW   = 6,
  parameter int              BTB_IW   = 4,
  parameter int              MAX_ITER = 4,
  parameter logic [PC_W-1:0] HASH_K   = 16'h9E37,
  localparam int             ITER_W   = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [DIR_IW-1:0] req_hist,
  input  logic              train_valid,
  input  logic [PC_W-1:0]   train_pc,
  input  logic [DIR_IW-1:0] train_hist,
  input  logic [PC_W-1:0]   train_target,
  output logic              busy,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic [PC_W-1:0]   pred_target,
  output logic [ITER_W-1:0] pred_iter
);
  localparam logic [ITER_W-1:0] LAST = ITER_W'(MAX_ITER - 1);

  vpc_state_e        state_q, state_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [DIR_IW-1:0] hist_q, hist_d;
  logic [PC_W-1:0]   tgt_q, tgt_d;
  logic              res_vld_d, res_hit_d;
  logic [PC_W-1:0]   res_tgt_d;

  logic [PC_W-1:0]   vpc;
  logic [DIR_IW-1:0] vhist;
  logic [DIR_IW-1:0] dir_idx;
  logic              dir_taken, dir_we, dir_wtaken;
  logic              btb_hit, btb_we;
  logic [PC_W-1:0]   btb_tgt;
  logic              is_last;

  function automatic logic [PC_W-1:0] step_hash(input logic [ITER_W-1:0] i);
    return PC_W'(i) * HASH_K;
  endfunction

  assign vpc     = pc_q ^ step_hash(iter_q);
  assign vhist   = hist_q << iter_q;
  assign dir_idx = vpc[DIR_IW-1:0] ^ vhist;
  assign is_last = (iter_q == LAST);

  vpc_dir_table #(.IW(DIR_IW)) dir_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (dir_idx),
    .taken    (dir_taken),
    .wr_en    (dir_we),
    .wr_taken (dir_wtaken)
  );

  vpc_btb #(.PC_W(PC_W), .IW(BTB_IW)) btb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (vpc),
    .hit       (btb_hit),
    .target    (btb_tgt),
    .wr_en     (btb_we),
    .wr_target (tgt_q)
  );

  always_comb begin
    state_d    = state_q;
    iter_d     = iter_q;
    pc_d       = pc_q;
    hist_d     = hist_q;
    tgt_d      = tgt_q;
    res_vld_d  = 1'b0;
    res_hit_d  = 1'b0;
    res_tgt_d  = pred_target;
    dir_we     = 1'b0;
    dir_wtaken = 1'b0;
    btb_we     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        iter_d = '0;
        if (req_valid) begin
          state_d = ST_PRED;
          pc_d    = req_pc;
          hist_d  = req_hist;
        end else if (train_valid) begin
          state_d = ST_TRAIN;
          pc_d    = train_pc;
          hist_d  = train_hist;
          tgt_d   = train_target;
        end
      end
      ST_PRED: begin
        if (!btb_hit || dir_taken || is_last) begin
          state_d   = ST_IDLE;
          res_vld_d = 1'b1;
          res_hit_d = btb_hit && dir_taken;
          res_tgt_d = btb_tgt;
        end else begin
          iter_d = iter_q + ITER_W'(1);
        end
      end
      ST_TRAIN: begin
        dir_we = 1'b1;
        if (btb_hit && (btb_tgt == tgt_q)) begin
          dir_wtaken = 1'b1;
          state_d    = ST_IDLE;
        end else if (!btb_hit || is_last) begin
          btb_we     = 1'b1;
          dir_wtaken = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          iter_d = iter_q + ITER_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      iter_q      <= '0;
      pc_q        <= '0;
      hist_q      <= '0;
      tgt_q       <= '0;
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_target <= '0;
      pred_iter   <= '0;
    end else begin
      state_q     <= state_d;
      iter_q      <= iter_d;
      pc_q        <= pc_d;
      hist_q      <= hist_d;
      tgt_q       <= tgt_d;
      pred_valid  <= res_vld_d;
      pred_hit    <= res_hit_d;
      if (res_vld_d) begin
        pred_target <= res_tgt_d;
        pred_iter   <= iter_q;
      end
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_STEP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRED && $past(state_q) == ST_PRED) |-> iter_q == $past(iter_q) + ITER_W'(1)); // R6
  AST_PULSE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> !busy); // R6
  AST_HIT_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> pred_valid); // R2
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (req_valid || train_valid)) |=> $stable(pc_q)); // R7
endmodule

// File: tb/vpc_indirect_pred_tb.sv
module vpc_indirect_pred_tb_top;
  localparam int PC_W = 16;
  localparam int HW   = 6;
  localparam int IW   = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [PC_W-1:0] req_pc = '0;
  logic [HW-1:0]   req_hist = '0;
  logic            train_valid = 1'b0;
  logic [PC_W-1:0] train_pc = '0;
  logic [HW-1:0]   train_hist = '0;
  logic [PC_W-1:0] train_target = '0;
  logic            busy, pred_valid, pred_hit;
  logic [PC_W-1:0] pred_target;
  logic [IW-1:0]   pred_iter;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic            hit;
    logic [PC_W-1:0] tgt;
    int              iter;
    int              start;
    string           req;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vpc_indirect_pred dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_pc(req_pc), .req_hist(req_hist),
    .train_valid(train_valid), .train_pc(train_pc), .train_hist(train_hist),
    .train_target(train_target),
    .busy(busy), .pred_valid(pred_valid), .pred_hit(pred_hit),
    .pred_target(pred_target), .pred_iter(pred_iter)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on each result pulse
  always @(negedge clk) begin
    if (rst_n && pred_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(pred_hit == e.hit, {e.req, " hit"}, pred_hit, e.hit);
        if (e.hit) check(pred_target == e.tgt, {e.req, " target"}, pred_target, e.tgt);
        check(int'(pred_iter) == e.iter, {e.req, " step"}, pred_iter, e.iter);
        check(cyc - e.start == e.iter + 2, "R6 latency", cyc - e.start, e.iter + 2);
      end
    end
  end

  task automatic predict(input logic [PC_W-1:0] pc, input logic [HW-1:0] h,
                         input logic hit, input logic [PC_W-1:0] tgt,
                         input int iter, input string req);
    exp_t e;
    @(negedge clk);
    e.hit = hit; e.tgt = tgt; e.iter = iter; e.start = cyc; e.req = req;
    sb_q.push_back(e);
    req_valid = 1'b1; req_pc = pc; req_hist = h;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input logic [HW-1:0] h,
                       input logic [PC_W-1:0] tgt);
    @(negedge clk);
    train_valid = 1'b1; train_pc = pc; train_hist = h; train_target = tgt;
    @(negedge clk);
    train_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    report();
  end

  localparam logic [PC_W-1:0] PA = 16'h1000, PB = 16'h2041;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(pred_valid == 1'b0, "R1 pred_valid after reset", pred_valid, 0);
    predict(PA, 6'h00, 1'b0, 16'h0, 0, "R1 R4 empty buffer");
    train(PA, 6'h00, 16'h4000);
    predict(PA, 6'h00, 1'b1, 16'h4000, 0, "R2 R9 first install");
    train(PA, 6'h00, 16'h5000);
    predict(PA, 6'h00, 1'b1, 16'h5000, 1, "R3 R8 step1");
    train(PA, 6'h00, 16'h4000);
    predict(PA, 6'h00, 1'b1, 16'h4000, 0, "R2 R8 lowest taken wins");
    train(PA, 6'h00, 16'h6000);
    predict(PA, 6'h00, 1'b1, 16'h6000, 2, "R3 R9 step2");
    train(PA, 6'h00, 16'h7000);
    predict(PA, 6'h00, 1'b1, 16'h7000, 3, "R3 R9 step3");
    // R5 with other history: all steps hit, all counters fresh; R7 drive during busy
    fork
      predict(PA, 6'h01, 1'b0, 16'h0, 3, "R5 R3 all not-taken");
      begin
        repeat (2) @(negedge clk);
        check(busy == 1'b1, "R6 busy during walk", busy, 1);
        req_valid = 1'b1; req_pc = PB; req_hist = 6'h3F;
        train_valid = 1'b1; train_pc = PB; train_hist = 6'h3F; train_target = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0; train_valid = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R7 no extra result", sb_q.size(), 0);
    predict(PB, 6'h3F, 1'b0, 16'h0, 0, "R7 dropped training left no entry");
    train(PA, 6'h00, 16'h8000);
    predict(PA, 6'h00, 1'b1, 16'h8000, 3, "R10 last step overwritten");
    // R11 saturation on PB
    train(PB, 6'h3F, 16'hA000);
    train(PB, 6'h3F, 16'hA000);
    train(PB, 6'h3F, 16'hA000);
    train(PB, 6'h3F, 16'hB000);
    predict(PB, 6'h3F, 1'b1, 16'hA000, 0, "R11 saturated counter held");
    train(PB, 6'h3F, 16'hB000);
    predict(PB, 6'h3F, 1'b1, 16'hB000, 1, "R8 R11 counter crossed");
    // R7 simultaneous request: predict wins
    @(negedge clk);
    begin
      exp_t e;
      e.hit = 1'b1; e.tgt = 16'hB000; e.iter = 1; e.start = cyc; e.req = "R7 predict over train";
      sb_q.push_back(e);
    end
    req_valid = 1'b1; req_pc = PB; req_hist = 6'h3F;
    train_valid = 1'b1; train_pc = PA; train_hist = 6'h00; train_target = 16'hCCCC;
    @(negedge clk);
    req_valid = 1'b0; train_valid = 1'b0;
    while (busy) @(negedge clk);
    predict(PA, 6'h00, 1'b1, 16'h8000, 3, "R7 dropped training no effect");
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 0);
    report();
  end
endmodule